// File: doc/BRIEF.md
# Sub-word Presence and Rank Lookup

This block serves one column slice of a ternary match table built from ordinary static memory. A sub-word of `W` bits is looked up in a presence bitmap that has one bit for every possible sub-word value. The bitmap is stored as `2^(W-B)` rows of `2^B` bits. The upper `W-B` bits of the sub-word pick a row and the lower `B` bits pick a bit inside it. The picked bit says whether the sub-word occurs in the slice.

Each row also carries a signed base field that is `W+1` bits wide. The base field holds the number of set bits in all rows below it, minus one, so row 0 holds -1. The block adds this base to the count of ones in the picked row from bit 0 up to and including the picked bit. The sum is a dense rank of the sub-word among all present sub-words. A later stage uses the rank to address a per-value table of entry positions.

Software or a loader fills rows through a single-cycle write port, one row with its base per cycle. A lookup is answered one cycle after it is issued. The answer gives a present flag and the rank, and the rank is forced to zero on a miss.

Top module: `subrank_lookup`

## Requirements
- R1: Sub-word bits `[W-1:B]` select the row and bits `[B-1:0]` select the bit position in that row. Rows are numbered from 0 and bit positions from bit 0 (the least significant bit of the row data).
- R2: `hit_present` equals the selected bit of the selected row as it stood when the lookup was issued.
- R3: On a hit, `hit_rank` equals the selected row's base field (two's complement, `W+1` bits) plus the number of ones in the row from bit 0 to the selected position inclusive, truncated to `W` bits.
- R4: With W=4, B=2, every bit set and row bases -1, 3, 7, 11, key 4'b1011 returns present with rank 11.
- R5: `hit_valid` is high exactly in the cycle after a cycle with `lookup_valid` high, so back-to-back lookups give back-to-back results.
- R6: When the selected bit is 0, `hit_present` is 0 and `hit_rank` is 0.
- R7: A write stores `wr_bits` and `wr_base` in row `wr_row` in one cycle. A lookup of that same row in the same cycle returns the old contents, and a later lookup returns the new contents.
- R8: After reset, and in every cycle with `hit_valid` low, `hit_present` and `hit_rank` are 0. Reset clears every row, so a lookup right after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lookup_valid | input | 1 | Issue a lookup this cycle |
| lookup_key | input | W | Sub-word to look up |
| wr_en | input | 1 | Write one row this cycle |
| wr_row | input | W-B | Row to write |
| wr_bits | input | 2^B | Presence bits for the row |
| wr_base | input | W+1 | Signed base field for the row |
| hit_valid | output | 1 | Result strobe, one cycle after `lookup_valid` |
| hit_present | output | 1 | Sub-word is present |
| hit_rank | output | W | Dense rank of the sub-word, 0 on a miss |

## Verification
The assertions assume that a repeated key sees the same stored row unless a write lands in the cycle before the repeat. The stimulus therefore places every write in a known cycle relative to the lookups around it. The table contents are assumed to be self-consistent, so that base fields are running counts and a hit never yields a negative rank. Every table the bench loads keeps to that rule, apart from the one deliberate row overwrite. In the bench, writes and lookups go through a single driver that updates its own model only after it has computed the expected result. This mirrors the rule that a lookup sees the state before a write issued in the same cycle.

// File: rtl/subrank_pkg.sv
// Shared defaults for the sub-word rank lookup.
// Assumes: KEY_W > POS_W >= 1, so a row has at least two bits and at
// least one row address bit exists.
package subrank_pkg;
    parameter int unsigned DEF_KEY_W = 6;  // sub-word width
    parameter int unsigned DEF_POS_W = 2;  // log2 of bits per row
endpackage

// File: rtl/subrank_row_store.sv
// Row store: presence bits plus signed base per row, one write port and a
// registered read port. A read and a write of the same row in one cycle
// returns the contents from before the write.
// Assumes: synchronous active-low reset clears all rows.
module subrank_row_store #(
    parameter int unsigned ROW_AW   = 4,
    parameter int unsigned ROW_BITS = 4,
    parameter int unsigned BASE_W   = 7,
    localparam int unsigned ROWS    = 1 << ROW_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_en,
    input  logic [ROW_AW-1:0]   rd_row,
    input  logic                wr_en,
    input  logic [ROW_AW-1:0]   wr_row,
    input  logic [ROW_BITS-1:0] wr_bits,
    input  logic [BASE_W-1:0]   wr_base,
    output logic [ROW_BITS-1:0] rd_bits,
    output logic [BASE_W-1:0]   rd_base
);
    logic [ROW_BITS-1:0] bits_mem [ROWS];
    logic [BASE_W-1:0]   base_mem [ROWS];

    // Per-row storage: clear on reset, load on a matching write.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bits_mem[r] <= '0;
                base_mem[r] <= '0;
            end else if (wr_en && (wr_row == ROW_AW'(r))) begin
                bits_mem[r] <= wr_bits;
                base_mem[r] <= wr_base;
            end
        end
    end

    // Registered read port, sees pre-write contents.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_bits <= '0;
            rd_base <= '0;
        end else if (rd_en) begin
            rd_bits <= bits_mem[rd_row];
            rd_base <= base_mem[rd_row];
        end
    end
endmodule

// File: rtl/subrank_prefix_count.sv
// Prefix population count: counts ones in a row from bit 0 up to and
// including the given position, and returns the bit at that position.
// Assumes: row width is a power of two, 2**POS_W.
module subrank_prefix_count #(
    parameter int unsigned POS_W  = 2,
    localparam int unsigned ROW_BITS = 1 << POS_W,
    localparam int unsigned CNT_W    = POS_W + 1
) (
    input  logic [ROW_BITS-1:0] row_bits,
    input  logic [POS_W-1:0]    pos,
    output logic                bit_at,
    output logic [CNT_W-1:0]    prefix_cnt
);
    logic [ROW_BITS-1:0] keep;

    // Thermometer mask: lane i is kept when i <= pos.
    for (genvar i = 0; i < ROW_BITS; i++) begin : g_mask
        assign keep[i] = row_bits[i] & (POS_W'(i) <= pos);
    end

    // Sum of kept lanes.
    always_comb begin
        prefix_cnt = '0;
        for (int i = 0; i < ROW_BITS; i++) begin
            prefix_cnt = prefix_cnt + CNT_W'(keep[i]);
        end
    end

    // Selected presence bit.
    assign bit_at = row_bits[pos];
endmodule

// File: rtl/subrank_lookup.sv
// Sub-word presence and rank lookup for one column slice of a
// memory-built ternary match table. One cycle of latency: the row is read
// into registers, then the prefix count and base are added.
// Assumes: W > B >= 1; table contents are loaded through the write port.
module subrank_lookup #(
    parameter int unsigned W = subrank_pkg::DEF_KEY_W,
    parameter int unsigned B = subrank_pkg::DEF_POS_W,
    localparam int unsigned ROW_AW   = W - B,
    localparam int unsigned ROW_BITS = 1 << B,
    localparam int unsigned BASE_W   = W + 1,
    localparam int unsigned CNT_W    = B + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lookup_valid,
    input  logic [W-1:0]        lookup_key,
    input  logic                wr_en,
    input  logic [ROW_AW-1:0]   wr_row,
    input  logic [ROW_BITS-1:0] wr_bits,
    input  logic [BASE_W-1:0]   wr_base,
    output logic                hit_valid,
    output logic                hit_present,
    output logic [W-1:0]        hit_rank
);
    logic [ROW_AW-1:0]   key_row;
    logic [B-1:0]        key_pos;
    logic [ROW_BITS-1:0] row_q;
    logic [BASE_W-1:0]   base_q;
    logic [B-1:0]        pos_q;
    logic                valid_q;
    logic                bit_sel;
    logic [CNT_W-1:0]    cnt;
    logic [BASE_W-1:0]   sum;

    // Key split into row address and in-row position.
    assign key_row = lookup_key[W-1:B];
    assign key_pos = lookup_key[B-1:0];

    subrank_row_store #(
        .ROW_AW   (ROW_AW),
        .ROW_BITS (ROW_BITS),
        .BASE_W   (BASE_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (lookup_valid),
        .rd_row  (key_row),
        .wr_en   (wr_en),
        .wr_row  (wr_row),
        .wr_bits (wr_bits),
        .wr_base (wr_base),
        .rd_bits (row_q),
        .rd_base (base_q)
    );

    // Position and strobe follow the row read by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            pos_q   <= '0;
        end else begin
            valid_q <= lookup_valid;
            if (lookup_valid) pos_q <= key_pos;
        end
    end

    subrank_prefix_count #(
        .POS_W (B)
    ) u_count (
        .row_bits   (row_q),
        .pos        (pos_q),
        .bit_at     (bit_sel),
        .prefix_cnt (cnt)
    );

    // Rank: base plus zero-extended prefix count, modulo 2**BASE_W.
    assign sum = base_q + {{(BASE_W-CNT_W){1'b0}}, cnt};

    // Output gating: quiet when no result, rank zero on a miss.
    always_comb begin
        hit_valid   = valid_q;
        hit_present = valid_q & bit_sel;
        hit_rank    = hit_present ? sum[W-1:0] : '0;
    end
endmodule

// File: rtl/subrank_lookup_chk.sv
// Checker for subrank_lookup: port-level timing and output rules.
// Assumes: reset is held for at least one clock at start.
module subrank_lookup_chk #(
    parameter int unsigned W = 6
) (
    input logic         clk,
    input logic         rst_n,
    input logic         lookup_valid,
    input logic [W-1:0] lookup_key,
    input logic         wr_en,
    input logic         hit_valid,
    input logic         hit_present,
    input logic [W-1:0] hit_rank
);
    AST_RESULT_FOLLOWS_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_valid |=> hit_valid); // R5

    AST_NO_SPURIOUS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !lookup_valid |=> !hit_valid); // R5

    AST_MISS_RANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_valid && !hit_present) |-> (hit_rank == '0)); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_valid |-> (!hit_present && hit_rank == '0)); // R8

    AST_REPEAT_KEY_SAME_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        (lookup_valid && $past(lookup_valid) && lookup_key == $past(lookup_key)
         && !$past(wr_en))
        |=> (hit_present == $past(hit_present) && hit_rank == $past(hit_rank))); // R2
endmodule

bind subrank_lookup subrank_lookup_chk #(.W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lookup_valid (lookup_valid),
    .lookup_key   (lookup_key),
    .wr_en        (wr_en),
    .hit_valid    (hit_valid),
    .hit_present  (hit_present),
    .hit_rank     (hit_rank)
);

// File: tb/subrank_lookup_bench.sv
// Scoreboard bench for subrank_lookup with W=4, B=2.
module subrank_lookup_bench;
    localparam int W = 4;
    localparam int B = 2;
    localparam int RAW = W - B;
    localparam int RB = 1 << B;
    localparam int NROWS = 1 << RAW;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic         pres;
        logic [W-1:0] rank;
        string        req;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lookup_valid = 1'b0;
    logic [W-1:0] lookup_key = '0;
    logic wr_en = 1'b0;
    logic [RAW-1:0] wr_row = '0;
    logic [RB-1:0] wr_bits = '0;
    logic [W:0] wr_base = '0;
    logic hit_valid, hit_present;
    logic [W-1:0] hit_rank;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    exp_t exp_q[$];
    logic [RB-1:0] mdl_bits [NROWS];
    logic [W:0]    mdl_base [NROWS];

    always #(CLK_PERIOD/2) clk = ~clk;

    subrank_lookup #(.W(W), .B(B)) u_subrank_lookup (
        .clk(clk), .rst_n(rst_n), .lookup_valid(lookup_valid),
        .lookup_key(lookup_key), .wr_en(wr_en), .wr_row(wr_row),
        .wr_bits(wr_bits), .wr_base(wr_base), .hit_valid(hit_valid),
        .hit_present(hit_present), .hit_rank(hit_rank)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // Driver: one cycle of stimulus; expected result uses pre-write model.
    task automatic step(input logic lv, input logic [W-1:0] k, input logic we,
                        input logic [RAW-1:0] r, input logic [RB-1:0] bits,
                        input logic [W:0] base, input string req);
        exp_t e;
        int   row, pos, cnt;
        logic [W:0] s;
        @(negedge clk);
        lookup_valid = lv; lookup_key = k;
        wr_en = we; wr_row = r; wr_bits = bits; wr_base = base;
        if (lv) begin
            row = int'(k[W-1:B]);
            pos = int'(k[B-1:0]);
            cnt = 0;
            for (int i = 0; i <= pos; i++) cnt += int'(mdl_bits[row][i]);
            e.pres = mdl_bits[row][pos];
            s = mdl_base[row] + (W+1)'(cnt);
            e.rank = e.pres ? s[W-1:0] : '0;
            e.req = req;
            exp_q.push_back(e);
        end
        if (we) begin
            mdl_bits[r] = bits;
            mdl_base[r] = base;
        end
    endtask

    task automatic look(input logic [W-1:0] k, input string req);
        step(1'b1, k, 1'b0, '0, '0, '0, req);
    endtask

    task automatic load(input logic [RAW-1:0] r, input logic [RB-1:0] bits,
                        input logic [W:0] base);
        step(1'b0, '0, 1'b1, r, bits, base, "");
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, '0, '0, '0, "");
    endtask

    // Monitor: compare each result strobe with the queued expectation.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (hit_valid) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R5", "unexpected hit_valid", 1, 0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        check(hit_present == e.pres, e.req, "hit_present",
                              int'(hit_present), int'(e.pres));
                        check(hit_rank == e.rank, e.req, "hit_rank",
                              int'(hit_rank), int'(e.rank));
                    end
                end else if (exp_q.size() != 0) begin
                    check(1'b0, "R5", "missing hit_valid", 0, 1);
                    void'(exp_q.pop_front());
                end
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog", "run did not finish", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        for (int r = 0; r < NROWS; r++) begin
            mdl_bits[r] = '0;
            mdl_base[r] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state at the ports
        check(!hit_valid, "R8", "hit_valid in reset", int'(hit_valid), 0);
        check(!hit_present && hit_rank == '0, "R8", "outputs in reset",
              int'(hit_rank), 0);
        rst_n = 1'b1;

        // R8: cleared table misses after reset
        look(4'd5, "R8");
        idle();
        @(negedge clk);
        // R5, R8: no lookup, no strobe, quiet outputs
        check(!hit_valid && !hit_present && hit_rank == '0, "R8", "idle outputs",
              int'(hit_valid), 0);

        // Full table, bases -1,3,7,11
        for (int r = 0; r < NROWS; r++) load(RAW'(r), '1, (W+1)'(4*r - 1));
        look(4'b1011, "R4");
        look(4'd0, "R3");
        look(4'd15, "R3");
        look(4'd6, "R1");
        look(4'd9, "R1");
        idle();

        // Sparse table: rows 0101/-1, 0000/1, 1000/1, 0110/2
        load(2'd0, 4'b0101, 5'h1F);
        load(2'd1, 4'b0000, 5'd1);
        load(2'd2, 4'b1000, 5'd1);
        load(2'd3, 4'b0110, 5'd2);
        look(4'd0, "R2");
        look(4'd2, "R3");
        look(4'd1, "R6");
        look(4'd7, "R6");
        look(4'd11, "R1");
        look(4'd13, "R3");
        look(4'd14, "R3");
        look(4'd14, "R2");
        idle();

        // R7: write row 1 while looking it up -> old (miss), then new
        step(1'b1, 4'd5, 1'b1, 2'd1, 4'b1111, 5'd1, "R7");
        look(4'd5, "R7");
        look(4'd4, "R7");
        idle();
        idle();
        idle();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule